// File: doc/BRIEF.md
# Qualified Clocked One-Shot

This block is a one-shot timer driven by the system clock. Three asynchronous control lines decide when it fires: an active-low edge input, an active-high edge input and an active-low clear. Each line is synchronized and edge-detected inside the block. When a trigger qualifies, the block copies the `width` input and holds `q` high for that many clock cycles. `q_n` always carries the inverse of `q`.

The parameter `RETRIG` selects the timing policy. When it is 1, each qualifying trigger reloads the full width, even during a pulse. When it is 0, triggers that arrive during a pulse are dropped. Releasing the clear can also start a pulse. In retriggerable mode, the release fires whenever the edge inputs are in their armed levels. In the other mode, the release fires only when the active-high input rose while the clear was still held low.

Top module: `qual_oneshot`

## Requirements
- R1: A low-to-high change on `trig_b` starts a pulse only when `trig_a_n` is 0 and `clr_n` is 1. In any other case it has no effect on `q`.
- R2: A high-to-low change on `trig_a_n` starts a pulse only when `trig_b` is 1 and `clr_n` is 1. In any other case it has no effect on `q`.
- R3: While the synchronized `clr_n` is 0, `q` is 0, and any pulse already running is cut short. `q` falls on the third rising clock edge after `clr_n` goes low.
- R4: With `RETRIG`=1, a qualifying trigger during a pulse reloads the count, so `q` stays high for `width` cycles counted from that trigger.
- R5: With `RETRIG`=0, a trigger arriving while `q` is high is ignored and the pulse ends at its original time.
- R6: With `RETRIG`=1, a low-to-high change on `clr_n` while `trig_a_n` is 0 and `trig_b` is 1 starts a pulse.
- R7: With `RETRIG`=0, a rising `clr_n` starts a pulse only if `trig_b` rose while `clr_n` was low and is still 1 at the release, with `trig_a_n` at 0.
- R8: `q_n` equals the inverse of `q` in every cycle, including during reset.
- R9: `q` rises on the third rising clock edge after a qualifying input change. It then stays high for exactly `width` cycles.
- R10: `width` is sampled only in the cycle a pulse is started. Later changes do not alter that pulse. A trigger with `width` = 0 produces no pulse.
- R11: If a trigger edge and the fall of `clr_n` reach the block in the same cycle, the clear wins and no pulse starts.
- R12: While `rst` is 1 and after it is released with idle inputs, `q` is 0 and `q_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_a_n | input | 1 | Active-low edge trigger (falling edge fires) |
| trig_b | input | 1 | Active-high edge trigger (rising edge fires) |
| clr_n | input | 1 | Active-low clear; its release can fire a pulse |
| width | input | WIDTH_W | Pulse length in clock cycles, sampled when the pulse starts |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Inverse of q |

## Verification
The latency assertion takes for granted that the control lines sit at their idle levels through reset and for a few cycles after it. Without that, the synchronizer's reset value could look like an input edge that never happened. The bench holds the lines idle during reset and lets each scenario settle for several cycles before its edge. The clear assertion counts consecutive low samples of `clr_n`, so it assumes the input is stable for a whole clock period. For that reason, every input change is driven on the falling clock edge. No scenario changes `width` in the cycle a trigger is taken.

// File: rtl/qos_pkg.sv
package qos_pkg;

    typedef struct packed {
        logic a_n;
        logic b;
        logic clr_n;
    } qos_ctl_t;

    localparam qos_ctl_t QOS_CTL_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};

    typedef struct packed {
        logic b_rise;
        logic a_fall;
        logic clr_rise;
    } qos_edge_t;

    typedef enum logic [1:0] {
        FIRE_NONE,
        FIRE_B,
        FIRE_A,
        FIRE_CLR
    } qos_fire_e;

    function automatic qos_edge_t qos_edges(input qos_ctl_t cur, input qos_ctl_t prv);
        qos_edge_t e;
        e.b_rise   = cur.b & ~prv.b;
        e.a_fall   = ~cur.a_n & prv.a_n;
        e.clr_rise = cur.clr_n & ~prv.clr_n;
        return e;
    endfunction

endpackage

// File: rtl/qos_sync.sv
module qos_sync #(
    parameter int          STAGES  = 2,
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qos_trig.sv
module qos_trig
    import qos_pkg::*;
#(
    parameter bit RETRIG = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  qos_ctl_t cur,
    output logic     fire,
    output logic     clear
);
    qos_ctl_t  prv;
    logic      primed;
    logic      release_ok;
    qos_edge_t e;
    qos_fire_e src;

    always_ff @(posedge clk) begin
        if (rst) begin
            prv    <= QOS_CTL_IDLE;
            primed <= 1'b0;
        end else begin
            prv <= cur;
            if (!cur.clr_n) primed <= primed | e.b_rise;
            else            primed <= 1'b0;
        end
    end

    generate
        if (RETRIG) begin : g_rel_any
            assign release_ok = 1'b1;
        end else begin : g_rel_primed
            assign release_ok = primed;
        end
    endgenerate

    always_comb begin
        e   = qos_edges(cur, prv);
        src = FIRE_NONE;
        if (e.clr_rise && !cur.a_n && cur.b && release_ok) src = FIRE_CLR;
        else if (e.b_rise && !cur.a_n && cur.clr_n)        src = FIRE_B;
        else if (e.a_fall && cur.b && cur.clr_n)           src = FIRE_A;
    end

    assign clear = ~cur.clr_n;
    assign fire  = (src != FIRE_NONE) && !clear;
endmodule

// File: rtl/qos_timer.sv
module qos_timer #(
    parameter int WIDTH_W = 8,
    parameter bit RETRIG  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               clear,
    input  logic [WIDTH_W-1:0] width,
    output logic               active
);
    localparam logic [WIDTH_W-1:0] ONE = 1;

    logic [WIDTH_W-1:0] rem;
    logic               idle_ok;
    logic               accept;

    generate
        if (RETRIG) begin : g_reload
            assign idle_ok = 1'b1;
        end else begin : g_hold
            assign idle_ok = (rem == '0);
        end
    endgenerate

    assign accept = fire && (width != '0) && idle_ok;

    always_ff @(posedge clk) begin
        if (rst)               rem <= '0;
        else if (clear)        rem <= '0;
        else if (accept)       rem <= width;
        else if (rem != '0)    rem <= rem - ONE;
    end

    assign active = (rem != '0);
endmodule

// File: rtl/qual_oneshot.sv
module qual_oneshot
    import qos_pkg::*;
#(
    parameter int WIDTH_W     = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit RETRIG      = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_a_n,
    input  logic               trig_b,
    input  logic               clr_n,
    input  logic [WIDTH_W-1:0] width,
    output logic               q,
    output logic               q_n
);
    localparam int CTL_W = $bits(qos_ctl_t);

    qos_ctl_t raw;
    qos_ctl_t synced;
    logic     fire;
    logic     clear;
    logic     active;

    assign raw = '{a_n: trig_a_n, b: trig_b, clr_n: clr_n};

    qos_sync #(
        .STAGES (SYNC_STAGES),
        .N      (CTL_W),
        .RST_VAL(QOS_CTL_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (synced)
    );

    qos_trig #(
        .RETRIG(RETRIG)
    ) u_trig (
        .clk  (clk),
        .rst  (rst),
        .cur  (synced),
        .fire (fire),
        .clear(clear)
    );

    qos_timer #(
        .WIDTH_W(WIDTH_W),
        .RETRIG (RETRIG)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .clear (clear),
        .width (width),
        .active(active)
    );

    assign q   = active;
    assign q_n = ~active;
endmodule

// File: rtl/qual_oneshot_chk.sv
module qual_oneshot_chk #(
    parameter int WIDTH_W = 8,
    parameter bit RETRIG  = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic trig_a_n,
    input logic trig_b,
    input logic clr_n,
    input logic q,
    input logic q_n
);
    localparam logic [WIDTH_W:0] MAXW = (1 << WIDTH_W) - 1;

    logic [3:0]       since_rst;
    logic [1:0]       clr_low;
    logic [WIDTH_W:0] run;
    logic [2:0]       ctl;

    assign ctl = {trig_a_n, trig_b, clr_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            clr_low   <= '0;
            run       <= '0;
        end else begin
            if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
            if (clr_n)                 clr_low <= '0;
            else if (clr_low != 2'd3)  clr_low <= clr_low + 2'd1;
            if (!q)                    run <= '0;
            else if (run <= MAXW)      run <= run + 1'b1;
        end
    end

    // R8: the two outputs are never equal
    assert_qn_compl_R8: assert property (@(posedge clk) q_n != q);

    // R3: three sampled low clears in a row force the output low
    assert_clr_holds_low_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_low == 2'd3) |-> !q);

    // R5: without retriggering no pulse can outlast the widest width
    assert_nr_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        (!RETRIG && q) |-> (run < MAXW));

    // R9: a new pulse needs an input change exactly three edges earlier
    assert_rise_needs_input_R9: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 4'd6) && $rose(q)) |-> ($past(ctl, 3) != $past(ctl, 4)));
endmodule

bind qual_oneshot qual_oneshot_chk #(
    .WIDTH_W(WIDTH_W),
    .RETRIG (RETRIG)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .trig_a_n(trig_a_n),
    .trig_b  (trig_b),
    .clr_n   (clr_n),
    .q       (q),
    .q_n     (q_n)
);

// File: tb/qual_oneshot_bench.sv
`timescale 1ns/1ps
module qual_oneshot_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       a_n, b, clr_n;
    logic [7:0] width;
    logic       q_r, qn_r, q_s, qn_s;
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qual_oneshot #(.WIDTH_W(8), .SYNC_STAGES(2), .RETRIG(1'b1)) u_qual_oneshot (
        .clk(clk), .rst(rst), .trig_a_n(a_n), .trig_b(b), .clr_n(clr_n),
        .width(width), .q(q_r), .q_n(qn_r));

    qual_oneshot #(.WIDTH_W(8), .SYNC_STAGES(2), .RETRIG(1'b0)) u_qual_oneshot_nr (
        .clk(clk), .rst(rst), .trig_a_n(a_n), .trig_b(b), .clr_n(clr_n),
        .width(width), .q(q_s), .q_n(qn_s));

    task automatic check(input string req, input string what, input logic act, input logic exp, input int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b (cycle %0d of scenario)", req, what, act, exp, k);
        end
    endtask

    // sample at the falling edge; k = rising edges since stimulus
    task automatic tick(input string req, input int base,
                        input int lo_r, input int hi_r, input int lo_n, input int hi_n);
        int  k;
        logic er, en;
        @(negedge clk);
        k  = cyc - base;
        er = (k >= lo_r) && (k <= hi_r);
        en = (k >= lo_n) && (k <= hi_n);
        check(req, "q retrig", q_r, er, k);
        check(req, "q non-retrig", q_s, en, k);
        check("R8", "q_n retrig", qn_r, ~q_r, k);
        check("R8", "q_n non-retrig", qn_s, ~q_s, k);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        rst = 1'b1; a_n = 1'b1; b = 1'b0; clr_n = 1'b1; width = 8'd0;
        settle(2);
        // R12: reset state
        check("R12", "q retrig in reset", q_r, 1'b0, 0);
        check("R12", "q non-retrig in reset", q_s, 1'b0, 0);
        check("R8", "q_n in reset", qn_r, 1'b1, 0);
        rst = 1'b0;
        settle(6);
        check("R12", "q after reset", q_r | q_s, 1'b0, 0);

        // R1, R9: rising B, width sweep
        for (int w = 1; w <= 6; w++) begin
            a_n = 1'b0; b = 1'b0; clr_n = 1'b1; width = w[7:0];
            settle(6);
            base = cyc; b = 1'b1;
            for (int i = 0; i < 12; i++) tick("R1/R9", base, 3, 2 + w, 3, 2 + w);
            b = 1'b0;
        end

        // R10: zero width gives nothing
        width = 8'd0; settle(6);
        base = cyc; b = 1'b1;
        for (int i = 0; i < 8; i++) tick("R10", base, 1, 0, 1, 0);
        b = 1'b0; width = 8'd4;

        // R1: rising B with A high is ignored
        a_n = 1'b1; settle(6);
        base = cyc; b = 1'b1;
        for (int i = 0; i < 8; i++) tick("R1", base, 1, 0, 1, 0);

        // R2, R10: falling A, width changed mid-pulse
        for (int w = 1; w <= 6; w++) begin
            a_n = 1'b1; b = 1'b1; clr_n = 1'b1; width = w[7:0];
            settle(6);
            base = cyc; a_n = 1'b0;
            for (int i = 0; i < 3; i++) tick("R2/R10", base, 3, 2 + w, 3, 2 + w);
            width = 8'd200;
            for (int i = 0; i < 9; i++) tick("R2/R10", base, 3, 2 + w, 3, 2 + w);
            a_n = 1'b1;
        end

        // R2: falling A with B low is ignored
        width = 8'd4; b = 1'b0; settle(6);
        base = cyc; a_n = 1'b0;
        for (int i = 0; i < 8; i++) tick("R2", base, 1, 0, 1, 0);

        // R4, R5: second trigger mid-pulse
        b = 1'b0; width = 8'd5; settle(6);
        base = cyc; b = 1'b1;
        for (int i = 0; i < 2; i++) tick("R4/R5", base, 3, 11, 3, 7);
        b = 1'b0;
        for (int i = 0; i < 2; i++) tick("R4/R5", base, 3, 11, 3, 7);
        b = 1'b1;
        for (int i = 0; i < 10; i++) tick("R4/R5", base, 3, 11, 3, 7);

        // R3: clear aborts a running pulse
        b = 1'b0; width = 8'd6; settle(6);
        base = cyc; b = 1'b1;
        for (int i = 0; i < 4; i++) tick("R3", base, 3, 6, 3, 6);
        clr_n = 1'b0;
        for (int i = 0; i < 8; i++) tick("R3", base, 3, 6, 3, 6);

        // R6, R7: release without priming
        base = cyc; clr_n = 1'b1;
        for (int i = 0; i < 12; i++) tick("R6/R7", base, 3, 8, 1, 0);

        // R6, R7: release after priming
        clr_n = 1'b0; settle(6);
        b = 1'b0; settle(5);
        b = 1'b1; settle(5);
        base = cyc; clr_n = 1'b1;
        for (int i = 0; i < 12; i++) tick("R6/R7", base, 3, 8, 3, 8);

        // R11: trigger and clear together
        a_n = 1'b1; b = 1'b1; clr_n = 1'b1; settle(8);
        base = cyc; a_n = 1'b0; clr_n = 1'b0;
        for (int i = 0; i < 8; i++) tick("R11", base, 1, 0, 1, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule